// File: doc/BRIEF.md
# I2C Register Bank Target

This block is an I2C target that gives a bus master access to a small bank of 8-bit registers. It samples the SCL and SDA lines through a two-stage synchroniser. From the sampled lines it detects START and STOP conditions and compares the first byte with a 7-bit device address set by a parameter. It acknowledges the bytes it accepts by pulling SDA low through an open-drain enable output.

An internal 8-bit byte pointer selects the register. In a write transfer, the first byte after the device address loads the pointer. Each later byte is stored at the pointer, and the pointer then advances by one. The pointer keeps its value across transfers and across repeated STARTs. This supports three kinds of read:

- A current-address read starts at the pointer's present value.
- A random-address read is a write phase that carries only the sub-address, followed by a repeated START and a read.
- A sequential read returns bytes from consecutive addresses for as long as the master acknowledges.

Each register has a fixed access type:

- Two read-only identification registers.
- A bank of read/write registers, each with its own reset value.
- A write-only soft-reset register. A write to it raises a single-cycle pulse.

Top module: `i2c_regbank_target`

## Requirements
- R1: After rst_ni is released, sda_oe_o is 0, soft_rst_o is 0 and the byte pointer is 0x00. A current-address read issued straight after reset therefore returns 0xAC.
- R2: The block acknowledges only an address byte whose upper seven bits equal DEV_ADDR; bit 0 of that byte is the R/W flag, where 1 means read. Any other address byte gets no acknowledge, and that transfer leaves the pointer and all registers unchanged.
- R3: In a write transfer, the first data byte loads the pointer. Each later data byte is stored at the pointer, and the pointer then increments by one. Every data byte is acknowledged.
- R4: A current-address read returns the byte at the pointer and then increments the pointer. The pointer keeps its value between transfers.
- R5: A random-address read works as follows. A write phase carries only the sub-address, then comes a repeated START, then the address byte with R/W set to 1. The read returns the register at that sub-address.
- R6: In a read, the target keeps returning bytes from consecutive addresses while the master acknowledges (SDA low in the ninth clock). After a NACK (SDA high in the ninth clock), the target releases SDA (sda_oe_o = 0) and drives nothing more until the next START.
- R7: Sub-address 0x00 reads 0xAC and sub-address 0x01 reads 0xA1. Both are read-only: a write to either is acknowledged but discarded.
- R8: A write to sub-address 0x10 raises soft_rst_o for exactly one clk_i cycle. Reads of 0x10, and reads of any unmapped address, return 0x00.
- R9: The read/write registers sit at 0x04 to 0x0B. The register at 0x04+k resets to 0x30+k.
- R10: SDA is only ever driven low. sda_oe_o rises only while the synchronised SCL is low.
- R11: The pointer wraps from 0xFF to 0x00. A sequential read starting at 0xFF returns 0x00 and then 0xAC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; must run much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND) |
| sda_oe_o | output | 1 | When 1, the pad pulls SDA low; when 0, SDA is released |
| soft_rst_o | output | 1 | Single-cycle pulse on each write to sub-address 0x10 |

## Verification
The assertions assume that the master changes SDA only while SCL is low, except when it forms a START or STOP. They also assume that each SCL phase lasts longer than the synchroniser delay. The bench master therefore holds every SCL half-period for many clk_i cycles and moves its own SDA a quarter period after each SCL fall. The master never starts a new START while the target is driving an acknowledge or a data bit. SDA is modelled as the wired-AND of the master's drive and the inverse of sda_oe_o.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK
  } i2c_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_sync_q, sda_sync_q;
  logic scl_prev_q, sda_prev_q;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_sync_q[g] <= 1'b1;
          sda_sync_q[g] <= 1'b1;
        end else if (g == 0) begin
          scl_sync_q[g] <= scl_i;
          sda_sync_q[g] <= sda_i;
        end else begin
          scl_sync_q[g] <= scl_sync_q[(g == 0) ? 0 : g-1];
          sda_sync_q[g] <= sda_sync_q[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_prev_q <= scl_o;
      sda_prev_q <= sda_o;
    end
  end

  assign scl_o      = scl_sync_q[SYNC_STAGES-1];
  assign sda_o      = sda_sync_q[SYNC_STAGES-1];
  assign scl_rise_o = scl_o & ~scl_prev_q;
  assign scl_fall_o = ~scl_o & scl_prev_q;
  // SDA edges with SCL held high form the bus conditions
  assign start_o    = scl_o & scl_prev_q & sda_prev_q & ~sda_o;
  assign stop_o     = scl_o & scl_prev_q & ~sda_prev_q & sda_o;
endmodule

// File: rtl/i2c_proto_fsm.sv
module i2c_proto_fsm
  import i2c_rb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h43
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              sda_oe_o,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic [BYTE_W-1:0] ptr_o,
  output i2c_state_e        state_o,
  output logic [3:0]        bit_cnt_o
);
  i2c_state_e        state_q;
  logic [3:0]        cnt_q;
  logic [BYTE_W-1:0] rx_q, tx_q, ptr_q, wa_q, wd_q;
  logic              rw_q, first_q, mack_q, oe_q, we_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;
      wa_q    <= '0;
      wd_q    <= '0;
      rw_q    <= 1'b0;
      first_q <= 1'b1;
      mack_q  <= 1'b0;
      oe_q    <= 1'b0;
      we_q    <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (start_i) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        first_q <= 1'b1;
        oe_q    <= 1'b0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR: begin
            if (scl_rise_i) begin
              rx_q  <= {rx_q[BYTE_W-2:0], sda_s_i};
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall_i && cnt_q == 4'd8) begin
              if (rx_q[7:1] == DEV_ADDR) begin
                rw_q    <= rx_q[0];
                oe_q    <= 1'b1;
                state_q <= ST_ADDR_ACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall_i) begin
              cnt_q <= '0;
              if (rw_q) begin
                tx_q    <= rd_data_i;
                oe_q    <= ~rd_data_i[7];
                ptr_q   <= ptr_q + 8'd1;
                state_q <= ST_RD_BYTE;
              end else begin
                oe_q    <= 1'b0;
                state_q <= ST_WR_BYTE;
              end
            end
          end
          ST_WR_BYTE: begin
            if (scl_rise_i) begin
              rx_q  <= {rx_q[BYTE_W-2:0], sda_s_i};
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall_i && cnt_q == 4'd8) begin
              oe_q    <= 1'b1;
              state_q <= ST_WR_ACK;
              if (first_q) begin
                ptr_q   <= rx_q;
                first_q <= 1'b0;
              end else begin
                we_q  <= 1'b1;
                wa_q  <= ptr_q;
                wd_q  <= rx_q;
                ptr_q <= ptr_q + 8'd1;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall_i) begin
              oe_q    <= 1'b0;
              cnt_q   <= '0;
              state_q <= ST_WR_BYTE;
            end
          end
          ST_RD_BYTE: begin
            if (scl_fall_i) begin
              if (cnt_q == 4'd7) begin
                oe_q    <= 1'b0;
                state_q <= ST_RD_ACK;
              end else begin
                tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
                oe_q  <= ~tx_q[6];
                cnt_q <= cnt_q + 4'd1;
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise_i) begin
              mack_q <= ~sda_s_i;
            end else if (scl_fall_i) begin
              if (mack_q) begin
                tx_q    <= rd_data_i;
                oe_q    <= ~rd_data_i[7];
                ptr_q   <= ptr_q + 8'd1;
                cnt_q   <= '0;
                state_q <= ST_RD_BYTE;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign sda_oe_o  = oe_q;
  assign wr_en_o   = we_q;
  assign wr_addr_o = wa_q;
  assign wr_data_o = wd_q;
  assign ptr_o     = ptr_q;
  assign state_o   = state_q;
  assign bit_cnt_o = cnt_q;
endmodule

// File: rtl/i2c_reg_map.sv
module i2c_reg_map
  import i2c_rb_pkg::*;
#(
  parameter int unsigned RW_BASE       = 4,
  parameter int unsigned RW_COUNT      = 8,
  parameter int unsigned RW_RST_BASE   = 8'h30,
  parameter int unsigned VERSION_ADDR  = 0,
  parameter int unsigned IDENT_ADDR    = 1,
  parameter int unsigned SOFT_RST_ADDR = 8'h10,
  parameter logic [7:0]  VERSION_VAL   = 8'hAC,
  parameter logic [7:0]  IDENT_VAL     = 8'hA1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [BYTE_W-1:0] rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              soft_rst_o
);
  logic [BYTE_W-1:0] rw_q [RW_COUNT];
  logic              srst_q;

  generate
    for (genvar g = 0; g < RW_COUNT; g++) begin : g_rw
      localparam logic [BYTE_W-1:0] RegAddr = BYTE_W'(RW_BASE + g);
      localparam logic [BYTE_W-1:0] RegRst  = BYTE_W'(RW_RST_BASE + g);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                             rw_q[g] <= RegRst;
        else if (wr_en_i && wr_addr_i == RegAddr) rw_q[g] <= wr_data_i;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) srst_q <= 1'b0;
    else         srst_q <= wr_en_i && (wr_addr_i == BYTE_W'(SOFT_RST_ADDR));
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == BYTE_W'(VERSION_ADDR))    rd_data_o = VERSION_VAL;
    else if (rd_addr_i == BYTE_W'(IDENT_ADDR)) rd_data_o = IDENT_VAL;
    for (int i = 0; i < RW_COUNT; i++) begin
      if (rd_addr_i == BYTE_W'(RW_BASE + i)) rd_data_o = rw_q[i];
    end
  end

  assign soft_rst_o = srst_q;
endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target
  import i2c_rb_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h43,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RW_BASE     = 4,
  parameter int unsigned RW_COUNT    = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o,
  output logic soft_rst_o
);
  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en;
  logic [BYTE_W-1:0] wr_addr, wr_data, ptr_w, rd_data;
  i2c_state_e        state_w;
  logic [3:0]        bit_cnt_w;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_proto_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_s_i    (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .rd_data_i  (rd_data),
    .sda_oe_o   (sda_oe_o),
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data),
    .ptr_o      (ptr_w),
    .state_o    (state_w),
    .bit_cnt_o  (bit_cnt_w)
  );

  i2c_reg_map #(.RW_BASE(RW_BASE), .RW_COUNT(RW_COUNT)) u_map (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .rd_addr_i  (ptr_w),
    .rd_data_o  (rd_data),
    .soft_rst_o (soft_rst_o)
  );
endmodule

// File: rtl/i2c_regbank_chk.sv
module i2c_regbank_chk
  import i2c_rb_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        scl_s,
  input logic        sda_oe_o,
  input logic        soft_rst_o,
  input i2c_state_e  state,
  input logic        wr_en,
  input logic [7:0]  wr_addr,
  input logic [7:0]  ptr,
  input logic [3:0]  bit_cnt
);
  a_r10_drive_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_s);

  a_r8_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> !soft_rst_o);

  a_r8_pulse_from_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |-> state == ST_WR_ACK);

  a_r3_ptr_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> ptr == wr_addr + 8'd1);

  a_r6_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_IDLE |-> !sda_oe_o);

  a_r6_bit_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_RD_BYTE |-> bit_cnt < 4'd8);
endmodule

bind i2c_regbank_target i2c_regbank_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_s      (scl_s),
  .sda_oe_o   (sda_oe_o),
  .soft_rst_o (soft_rst_o),
  .state      (state_w),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .ptr        (ptr_w),
  .bit_cnt    (bit_cnt_w)
);

// File: tb/test_i2c_regbank_target.sv
module test_i2c_regbank_target;
  localparam logic [6:0] DEV = 7'h43;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, soft_rst;
  logic sda_line;
  int checks = 0;
  int errors = 0;
  int bad_rise = 0;
  int soft_hi = 0;
  int soft_edges = 0;
  logic oe_prev = 1'b0, soft_prev = 1'b0;
  logic [7:0] shadow [8];

  assign sda_line = sda_m & ~sda_oe;
  always #5 clk = ~clk;

  i2c_regbank_target #(.DEV_ADDR(DEV)) i_i2c_regbank_target (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .soft_rst_o(soft_rst)
  );

  always @(posedge clk) begin
    if (sda_oe && !oe_prev && scl_m) bad_rise++;
    if (soft_rst) soft_hi++;
    if (soft_rst && !soft_prev) soft_edges++;
    oe_prev   <= sda_oe;
    soft_prev <= soft_rst;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); acked = !sda_line; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl_m = 1'b1; wq(); b[i] = sda_line; wq(); scl_m = 1'b0;
    end
    wq(); sda_m = !give_ack; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    if (a == 8'h00) return 8'hAC;
    if (a == 8'h01) return 8'hA1;
    if (a >= 8'h04 && a <= 8'h0B) return shadow[a - 8'h04];
    return 8'h00;
  endfunction

  task automatic cur_read(input string req, input logic [7:0] exp);
    logic ak;
    logic [7:0] d;
    bus_start();
    send_byte({DEV, 1'b1}, ak);
    chk("R2", {7'd0, ak}, 8'd1);
    recv_byte(1'b0, d);
    chk(req, d, exp);
    bus_stop();
  endtask

  task automatic rand_read(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic ak;
    logic [7:0] d;
    bus_start();
    send_byte({DEV, 1'b0}, ak);
    send_byte(a, ak);
    bus_start();
    send_byte({DEV, 1'b1}, ak);
    chk("R5", {7'd0, ak}, 8'd1);
    recv_byte(1'b0, d);
    chk(req, d, exp);
    bus_stop();
  endtask

  initial begin
    logic ak;
    logic [7:0] d;
    for (int k = 0; k < 8; k++) shadow[k] = 8'h30 + 8'(k);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {7'd0, sda_oe}, 8'd0);
    chk("R1", {7'd0, soft_rst}, 8'd0);
    cur_read("R1", 8'hAC);
    chk("R6", {7'd0, sda_oe}, 8'd0);
    cur_read("R4", 8'hA1);

    // R2 foreign address ignored, pointer stays at 0x02
    bus_start();
    send_byte({DEV ^ 7'h01, 1'b1}, ak);
    chk("R2", {7'd0, ak}, 8'd0);
    bus_stop();
    cur_read("R2", 8'h00);

    // R9 reset values via random reads
    for (int k = 0; k < 8; k++) rand_read("R9", 8'h04 + 8'(k), 8'h30 + 8'(k));

    // R3 block write
    bus_start();
    send_byte({DEV, 1'b0}, ak);
    send_byte(8'h04, ak);
    chk("R3", {7'd0, ak}, 8'd1);
    for (int k = 0; k < 8; k++) begin
      d = 8'h5A ^ 8'(k * 37);
      send_byte(d, ak);
      chk("R3", {7'd0, ak}, 8'd1);
      shadow[k] = d;
    end
    bus_stop();

    // R3 pointer moves past the written byte
    bus_start();
    send_byte({DEV, 1'b0}, ak);
    send_byte(8'h06, ak);
    send_byte(8'hC3, ak);
    shadow[2] = 8'hC3;
    bus_stop();
    cur_read("R3", shadow[3]);

    // R7 write to read-only is acknowledged and discarded
    bus_start();
    send_byte({DEV, 1'b0}, ak);
    send_byte(8'h00, ak);
    send_byte(8'h12, ak);
    chk("R7", {7'd0, ak}, 8'd1);
    send_byte(8'h34, ak);
    chk("R7", {7'd0, ak}, 8'd1);
    bus_stop();
    rand_read("R7", 8'h00, 8'hAC);
    rand_read("R7", 8'h01, 8'hA1);

    // R8 soft reset pulse
    chk("R8", 8'(soft_edges), 8'd0);
    bus_start();
    send_byte({DEV, 1'b0}, ak);
    send_byte(8'h10, ak);
    send_byte(8'h5A, ak);
    chk("R8", {7'd0, ak}, 8'd1);
    bus_stop();
    chk("R8", 8'(soft_edges), 8'd1);
    chk("R8", 8'(soft_hi), 8'd1);
    rand_read("R8", 8'h10, 8'h00);
    rand_read("R5", 8'h0B, shadow[7]);

    // R11 wrap
    rand_read("R11", 8'hFF, 8'h00);
    cur_read("R11", 8'hAC);

    // R6 full sequential sweep from 0x00, 257 bytes, last wraps
    bus_start();
    send_byte({DEV, 1'b0}, ak);
    send_byte(8'h00, ak);
    bus_start();
    send_byte({DEV, 1'b1}, ak);
    for (int i = 0; i < 257; i++) begin
      recv_byte(i != 256, d);
      if (i == 256)          chk("R11", d, 8'hAC);
      else if (i < 2)        chk("R7", d, exp_rd(8'(i)));
      else if (i == 16)      chk("R8", d, 8'h00);
      else                   chk("R6", d, exp_rd(8'(i)));
    end
    chk("R6", {7'd0, sda_oe}, 8'd0);
    bus_stop();

    chk("R10", 8'(bad_rise), 8'd0);
    chk("R8", 8'(soft_edges), 8'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule